// File: doc/BRIEF.md
# Guarded Configuration Register Bank

This block is the register file behind a two-wire serial slave that answers device address 0x55. A protocol engine, outside this block, turns bus transactions into single-byte accesses: a 7-bit device address, a 7-bit register address, a write strobe with a data byte, and a read data byte returned in the same cycle. The register space runs from 0x00 to 0x7F. Part of it holds configuration bytes. A few addresses return a fixed release code or a mirrored copy of other bytes. Four addresses expose live error flags, gated by a mask.

Whether a write lands depends on the address and on a run-enable bit, bit 7 of register 0x02, which starts and halts a downstream converter. While the converter runs, its mode bits and a block of tuning bytes are frozen. The run bit may only be flipped by a byte that repeats the current mode bits. Any write the bank refuses leaves storage untouched and raises a one-cycle rejected flag. The run bit goes out as a level, and a single-cycle restart pulse marks each start.

Top module: `cfg_guard_bank`

## Requirements
- R1: After synchronous reset every configuration byte reads 0x00, except register 0x17, which reads 0x08. run_en is 0 and restart is 0.
- R2: An access takes effect only when acc_dev equals 0x55. Otherwise a write changes nothing and does not raise wr_reject, and a read returns 0x00.
- R3: Registers 0x00, 0x01, 0x03–0x16, 0x18, 0x2B–0x2E and 0x30–0x33 take any write at the clock edge that samples acc_we, and read it back afterwards.
- R4: A write to 0x17 stores bits 7:4 and 2:0 as given and always leaves bit 3 at 1. Such a write is never rejected.
- R5: Registers 0x19–0x21 accept writes only while run_en is 0. While run_en is 1, a write to them is rejected.
- R6: A write to 0x02 is accepted when its bits 6:0 equal the stored bits 6:0, or when run_en is 0 and the written bit 7 is 0. Every other write to 0x02 is rejected.
- R7: run_en equals bit 7 of register 0x02. restart is high for exactly the one cycle after the edge where run_en goes from 0 to 1.
- R8: Addresses 0x2F and 0x3F read the REL_CODE parameter (default 0x09). Addresses 0x3B–0x3E read the contents of 0x2B–0x2E, one to one.
- R9: Address 0x40+i (i = 0..3) reads err_in[8i+7:8i] AND register 0x2B+i.
- R10: A write to 0x22–0x2A, 0x2F, 0x34–0x7F, or a rejected write under R5 or R6, changes no storage. It drives wr_reject high for exactly the cycle after that write's edge.
- R11: Reads of 0x22–0x2A, 0x34–0x3A and 0x44–0x7F return 0x00.
- R12: acc_rdata follows acc_addr in the same cycle. An accepted write shows in acc_rdata from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_dev | input | 7 | Device address of the current access |
| acc_addr | input | 7 | Register address |
| acc_we | input | 1 | Write strobe, one byte per cycle |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for acc_addr (combinational) |
| wr_reject | output | 1 | One-cycle pulse after a refused write |
| err_in | input | 32 | Live error flags, byte i seen at 0x40+i |
| run_en | output | 1 | Converter run-enable level |
| restart | output | 1 | One-cycle pulse on each converter start |

## Verification
The embedded properties check several things on every cycle: the restart pulse coincides with a rising run_en, the mode bits of 0x02 never move while running, the locked tuning bytes hold while running, register 0x17 keeps bit 3 set, and a rejected write leaves all storage stable. Only the bench scenarios show the read side: mirror and release values, masked error bytes, and zero for unimplemented or foreign-device reads. They also show which specific byte values each guarded write accepts or refuses.

// File: rtl/cfg_guard_pkg.sv
// Package: shared types and constants of the guarded configuration bank.
// Assumes a 7-bit register space and byte-wide data.
package cfg_guard_pkg;
    localparam int unsigned ADDR_W    = 7;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ERR_BYTES = 4;
    localparam int unsigned N_CFG     = 42;               // implemented storage bytes
    localparam int unsigned IDX_W     = $clog2(N_CFG);
    localparam int unsigned MODE_IDX  = 2;
    localparam int unsigned SLAVE_IDX = 23;               // 0x17
    localparam int unsigned LOCK_LO   = 25;               // 0x19
    localparam int unsigned LOCK_HI   = 33;               // 0x21
    localparam int unsigned MASK_IDX  = 34;               // storage of 0x2B
    localparam int unsigned UPPER_IDX = 38;               // storage of 0x30
    localparam logic [DATA_W-1:0] SLAVE_KEEP = 8'h08;     // bit that must stay set

    typedef enum logic [2:0] {
        RG_OPEN, RG_MODE, RG_SLAVE, RG_LOCKED,
        RG_RELEASE, RG_MIRROR, RG_ERROR, RG_NONE
    } region_e;
endpackage

// File: rtl/cfg_guard_decode.sv
// Address decoder: classifies a register address into a region and maps it
// to a storage index or an error-byte select. Purely combinational.
module cfg_guard_decode
    import cfg_guard_pkg::*;
(
    input  logic [ADDR_W-1:0]            addr,
    output region_e                      region,
    output logic [IDX_W-1:0]             idx,
    output logic [$clog2(ERR_BYTES)-1:0] err_sel
);
    // Map the address onto its region and storage slot
    always_comb begin
        region  = RG_NONE;
        idx     = '0;
        err_sel = '0;
        if (addr == 7'h02) begin
            region = RG_MODE;
            idx    = IDX_W'(MODE_IDX);
        end else if (addr == 7'h17) begin
            region = RG_SLAVE;
            idx    = IDX_W'(SLAVE_IDX);
        end else if (addr >= 7'h19 && addr <= 7'h21) begin
            region = RG_LOCKED;
            idx    = IDX_W'(addr);
        end else if (addr <= 7'h21) begin
            region = RG_OPEN;
            idx    = IDX_W'(addr);
        end else if (addr >= 7'h2B && addr <= 7'h2E) begin
            region = RG_OPEN;
            idx    = IDX_W'(addr - 7'h2B + 7'(MASK_IDX));
        end else if (addr == 7'h2F || addr == 7'h3F) begin
            region = RG_RELEASE;
        end else if (addr >= 7'h30 && addr <= 7'h33) begin
            region = RG_OPEN;
            idx    = IDX_W'(addr - 7'h30 + 7'(UPPER_IDX));
        end else if (addr >= 7'h3B && addr <= 7'h3E) begin
            region = RG_MIRROR;
            idx    = IDX_W'(addr - 7'h3B + 7'(MASK_IDX));
        end else if (addr >= 7'h40 && addr <= 7'h43) begin
            region  = RG_ERROR;
            err_sel = addr[$clog2(ERR_BYTES)-1:0];
        end
    end
endmodule

// File: rtl/cfg_guard_policy.sv
// Write policy: decides whether a write is accepted and what byte is stored.
// Assumes cur_byte is the present content of the addressed slot.
module cfg_guard_policy
    import cfg_guard_pkg::*;
(
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_byte,
    input  logic              running,
    output logic              accept,
    output logic [DATA_W-1:0] store_val
);
    logic same_mode;
    assign same_mode = (wdata[6:0] == cur_byte[6:0]);

    // Apply the per-region acceptance rule
    always_comb begin
        accept    = 1'b0;
        store_val = wdata;
        unique case (region)
            RG_OPEN:   accept = 1'b1;
            RG_SLAVE: begin
                accept    = 1'b1;
                store_val = wdata | SLAVE_KEEP;
            end
            RG_LOCKED: accept = !running;
            RG_MODE:   accept = same_mode || (!running && !wdata[7]);
            default:   accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_guard_store.sv
// Storage: one register per implemented byte. It updates the slot named by idx
// when we is high. The slave-enable bit resets to 1 and everything else to 0.
module cfg_guard_store
    import cfg_guard_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wval,
    output logic [N_CFG-1:0][DATA_W-1:0]  bytes
);
    for (genvar i = 0; i < N_CFG; i++) begin : g_byte
        localparam logic [DATA_W-1:0] RST_VAL = (i == SLAVE_IDX) ? SLAVE_KEEP : '0;
        // Hold or update one configuration byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes[i] <= RST_VAL;
            else if (we && idx == IDX_W'(i))
                bytes[i] <= wval;
        end
    end
endmodule

// File: rtl/cfg_guard_bank.sv
// Top: guarded configuration register bank behind a serial slave port.
// Assumes one access per cycle, with read data taken combinationally.
module cfg_guard_bank
    import cfg_guard_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h55,
    parameter logic [DATA_W-1:0] REL_CODE = 8'h09
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           acc_dev,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic                        acc_we,
    input  logic [DATA_W-1:0]           acc_wdata,
    output logic [DATA_W-1:0]           acc_rdata,
    output logic                        wr_reject,
    input  logic [8*ERR_BYTES-1:0]      err_in,
    output logic                        run_en,
    output logic                        restart
);
    region_e                          region;
    logic [IDX_W-1:0]                 idx;
    logic [$clog2(ERR_BYTES)-1:0]     err_sel;
    logic [N_CFG-1:0][DATA_W-1:0]     bytes;
    logic [DATA_W-1:0]                cur_byte, store_val;
    logic                             accept, dev_hit, wr_ok;
    logic [DATA_W-1:0]                err_byte [ERR_BYTES];

    cfg_guard_decode u_dec (.addr(acc_addr), .region(region), .idx(idx), .err_sel(err_sel));

    assign cur_byte = bytes[idx];
    assign run_en   = bytes[MODE_IDX][7];
    assign dev_hit  = (acc_dev == DEV_ADDR);

    cfg_guard_policy u_pol (
        .region(region), .wdata(acc_wdata), .cur_byte(cur_byte),
        .running(run_en), .accept(accept), .store_val(store_val)
    );

    assign wr_ok = acc_we && dev_hit && accept;

    cfg_guard_store u_st (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .idx(idx),
        .wval(store_val), .bytes(bytes)
    );

    for (genvar e = 0; e < ERR_BYTES; e++) begin : g_err
        assign err_byte[e] = err_in[8*e +: 8] & bytes[MASK_IDX+e];
    end

    // Select the read byte for the addressed region
    always_comb begin
        acc_rdata = '0;
        if (dev_hit) begin
            unique case (region)
                RG_OPEN, RG_MODE, RG_SLAVE, RG_LOCKED, RG_MIRROR: acc_rdata = cur_byte;
                RG_RELEASE: acc_rdata = REL_CODE;
                RG_ERROR:   acc_rdata = err_byte[err_sel];
                default:    acc_rdata = '0;
            endcase
        end
    end

    // Flag refused writes and converter starts for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_reject <= 1'b0;
            restart   <= 1'b0;
        end else begin
            wr_reject <= acc_we && dev_hit && !accept;
            restart   <= wr_ok && region == RG_MODE && acc_wdata[7] && !run_en;
        end
    end

    // R7: a restart pulse only follows a 0->1 edge of run_en
    a_r7_restart_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (run_en && !$past(run_en)));
    // R7: every rise of run_en comes with a restart pulse
    a_r7_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(run_en)) |-> restart);
    // R6: the mode bits never move while the converter runs
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en)) |-> (bytes[MODE_IDX][6:0] == $past(bytes[MODE_IDX][6:0])));
    // R4: the slave-enable bit of 0x17 stays set
    a_r4_slave_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        bytes[SLAVE_IDX][3]);
    // R10: a rejected write leaves all storage unchanged
    a_r10_reject_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wr_reject) |-> $stable(bytes));
    // R10: writes to read-only regions are always flagged
    a_r10_readonly_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_we && dev_hit &&
            (region == RG_RELEASE || region == RG_ERROR || region == RG_MIRROR))) |-> wr_reject);
    for (genvar k = LOCK_LO; k <= LOCK_HI; k++) begin : g_lock_chk
        // R5: locked tuning bytes hold while running
        a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(run_en)) |-> $stable(bytes[k]));
    end
endmodule

// File: tb/sim_cfg_guard_bank.sv
// Scoreboard bench: driver tasks queue expected items, and a monitor pops and
// compares them at the falling edge that follows each access.
module sim_cfg_guard_bank;
    localparam logic [6:0] DEV = 7'h55;
    localparam logic [7:0] REL = 8'h09;
    localparam int K_RD = 0, K_REJ = 1, K_RUN = 2, K_RST = 3;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic        clk = 0, rst_n = 0, acc_we = 0, mon_go = 0, done = 0;
    logic [6:0]  acc_dev = DEV, acc_addr = '0;
    logic [7:0]  acc_wdata = '0, acc_rdata;
    logic [31:0] err_in = '0;
    logic        wr_reject, run_en, restart;
    item_t       q[$];
    int          nchk = 0, nfail = 0;

    cfg_guard_bank #(.DEV_ADDR(DEV), .REL_CODE(REL)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_dev(acc_dev), .acc_addr(acc_addr),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .wr_reject(wr_reject), .err_in(err_in), .run_en(run_en), .restart(restart)
    );

    always #10 clk = ~clk;

    task automatic expect_sig(input int kind, input logic [7:0] v, input string tag);
        item_t it;
        it.kind = kind; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input bit rej,
                      input string tag, input logic [6:0] dev = DEV);
        @(posedge clk); #2;
        acc_dev = dev; acc_addr = a; acc_wdata = d; acc_we = 1;
        @(posedge clk); #2;
        acc_we = 0; acc_dev = DEV;
        expect_sig(K_REJ, {7'd0, rej}, tag);
        mon_go = 1;
        @(posedge clk); #2;
        mon_go = 0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] v, input string tag,
                      input logic [6:0] dev = DEV);
        @(posedge clk); #2;
        acc_dev = dev; acc_addr = a;
        expect_sig(K_RD, v, tag);
        mon_go = 1;
        @(posedge clk); #2;
        mon_go = 0; acc_dev = DEV;
    endtask

    // Monitor: pop every pending item and compare it with the live outputs
    always @(negedge clk) begin
        if (mon_go) begin
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    got = acc_rdata;
                    K_REJ:   got = {7'd0, wr_reject};
                    K_RUN:   got = {7'd0, run_en};
                    default: got = {7'd0, restart};
                endcase
                nchk++;
                if (got !== it.exp) begin
                    nfail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        expect_sig(K_RUN, 8'h00, "R1 run_en after reset");
        expect_sig(K_RST, 8'h00, "R1 restart after reset");
        rd(7'h17, 8'h08, "R1 slave reg reset");
        rd(7'h02, 8'h00, "R1 mode reg reset");
        rd(7'h05, 8'h00, "R1 cfg byte reset");
        // R8 release code
        rd(7'h2F, REL, "R8 release at 0x2F");
        rd(7'h3F, REL, "R8 release at 0x3F");
        // R3 open writes, R12 visible next cycle
        wr(7'h05, 8'hA5, 0, "R3 write 0x05");
        rd(7'h05, 8'hA5, "R12 readback 0x05");
        wr(7'h2B, 8'h0F, 0, "R3 write 0x2B");
        rd(7'h2B, 8'h0F, "R3 readback 0x2B");
        rd(7'h3B, 8'h0F, "R8 mirror 0x3B");
        wr(7'h30, 8'h3C, 0, "R3 write 0x30");
        rd(7'h30, 8'h3C, "R3 readback 0x30");
        wr(7'h18, 8'h77, 0, "R3 write 0x18");
        rd(7'h18, 8'h77, "R3 readback 0x18");
        // R4 slave bit kept
        wr(7'h17, 8'h00, 0, "R4 write 0x17 zero");
        rd(7'h17, 8'h08, "R4 bit3 kept");
        wr(7'h17, 8'hF0, 0, "R4 write 0x17 F0");
        rd(7'h17, 8'hF8, "R4 other bits stored");
        // R2 foreign device
        wr(7'h05, 8'h11, 0, "R2 foreign write no flag", 7'h50);
        rd(7'h05, 8'hA5, "R2 foreign write no effect");
        rd(7'h05, 8'h00, "R2 foreign read zero", 7'h50);
        // R5 locked bytes while halted
        wr(7'h19, 8'h5A, 0, "R5 write 0x19 halted");
        rd(7'h19, 8'h5A, "R5 readback 0x19");
        // R6 mode/run rules
        wr(7'h02, 8'h15, 0, "R6 mode change halted");
        wr(7'h02, 8'h97, 1, "R6 start with mode change");
        rd(7'h02, 8'h15, "R6 mode unchanged after reject");
        expect_sig(K_RUN, 8'h01, "R7 run_en after start");
        expect_sig(K_RST, 8'h01, "R7 restart pulse");
        wr(7'h02, 8'h95, 0, "R6 start same mode");
        expect_sig(K_RST, 8'h00, "R7 restart one cycle");
        rd(7'h02, 8'h95, "R6 readback running");
        // R5 locked while running
        wr(7'h19, 8'h66, 1, "R5 write 0x19 running");
        rd(7'h19, 8'h5A, "R5 0x19 unchanged");
        wr(7'h21, 8'h01, 1, "R5 write 0x21 running");
        rd(7'h21, 8'h00, "R5 0x21 unchanged");
        // R6 while running
        wr(7'h02, 8'h96, 1, "R6 mode change running");
        wr(7'h02, 8'h16, 1, "R6 halt with mode change");
        rd(7'h02, 8'h95, "R6 still running");
        expect_sig(K_RST, 8'h00, "R7 no pulse on rewrite");
        wr(7'h02, 8'h95, 0, "R6 rewrite same byte");
        expect_sig(K_RUN, 8'h00, "R7 run_en after halt");
        wr(7'h02, 8'h15, 0, "R6 halt same mode");
        rd(7'h02, 8'h15, "R6 readback halted");
        // R10 read-only and unimplemented writes
        wr(7'h2F, 8'h00, 1, "R10 write release");
        rd(7'h2F, REL, "R10 release unchanged");
        wr(7'h3B, 8'h00, 1, "R10 write mirror");
        rd(7'h2B, 8'h0F, "R10 mirror source unchanged");
        wr(7'h40, 8'hFF, 1, "R10 write error window");
        wr(7'h34, 8'h12, 1, "R10 write 0x34");
        wr(7'h50, 8'h12, 1, "R10 write unimplemented");
        // R11 unimplemented reads
        rd(7'h50, 8'h00, "R11 read 0x50");
        rd(7'h22, 8'h00, "R11 read 0x22");
        rd(7'h38, 8'h00, "R11 read 0x38");
        // R9 masked error window
        wr(7'h2C, 8'hFF, 0, "R9 mask byte1");
        wr(7'h2D, 8'h33, 0, "R9 mask byte2");
        wr(7'h2E, 8'h00, 0, "R9 mask byte3");
        err_in = 32'hF0C3_A57E;
        rd(7'h40, 8'h0E, "R9 error byte0");
        rd(7'h41, 8'hA5, "R9 error byte1");
        rd(7'h42, 8'h03, "R9 error byte2");
        rd(7'h43, 8'h00, "R9 error byte3");
        rd(7'h3D, 8'h33, "R8 mirror 0x3D");
        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule